// File: doc/BRIEF.md
# Multiframe Sequencer with Subchannel Latch

This block keeps track of where a basic-rate S/T line interface currently is inside its 20-frame multiframe. A multiframe spans 5 ms. The block takes a strobe for each baud and a strobe at the start of each frame. It counts baud positions 1 to 48 inside a frame and frame positions 1 to 20 inside a multiframe. An extra indication that a multiframe is starting, given together with a frame start, realigns the frame count.

One fixed point is the boundary of each multiframe: the 47th baud of the 20th frame. At that point the block does three things:
- When the block acts as the network side, it stores the outgoing subchannel bits from host-written fields. These are one nibble and two bytes, 20 bits in all.
- In both roles it stores the received nibble so the host can read it. This nibble is the Q nibble on the network side or SC1 on the terminal side.
- It can emit a one-cycle event strobe for the interrupt logic.

In filter mode the strobe is emitted only when the received nibble differs from the nibble stored at the previous boundary. A control input enables multiframing. While that input is low, both counters are held at zero.

Top module: `mframe_seq`

## Requirements
- R1: While `mf_enable` is low, `baud_pos` and `frame_pos` read 0, no event is raised and neither hold register changes.
- R2: With multiframing enabled, each `baud_stb` advances `baud_pos` from 48 (or 0) to 1 and otherwise by one. A `baud_stb` together with `frame_stb` sets it to 1.
- R3: A new frame begins on a baud strobe with `frame_stb` high, or on a baud strobe when `baud_pos` is 48 or 0. At a new frame, `frame_pos` goes from 20 (or 0) to 1 and otherwise goes up by one. If `mf_sync` is high at a new frame, `frame_pos` is set to 1.
- R4: The boundary is the baud strobe that makes `baud_pos` 47 while `frame_pos` is 20. At the boundary with `role_nt` high, `tx_hold` takes `{tx_nib, tx_bytes}` (nibble in bits 19:16, bytes in 15:0). With `role_nt` low, `tx_hold` is unchanged.
- R5: At the boundary `rx_hold` takes `rx_nib`, in both roles.
- R6: With `evt_enable` high and `filter_mode` low, `mf_event` is high for exactly one cycle, the cycle right after the boundary strobe, while `baud_pos` is 47 and `frame_pos` is 20. It is low at all other times.
- R7: With `filter_mode` high, the boundary raises `mf_event` only when `rx_nib` differs from the `rx_hold` value held just before that boundary.
- R8: With `evt_enable` low, no event is raised, but both hold registers still capture at the boundary.
- R9: Reset clears counters, hold registers and `mf_event`. Between boundaries the hold registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mf_enable | input | 1 | Multiframing enable; low holds the counters at 0 |
| evt_enable | input | 1 | Event enable |
| role_nt | input | 1 | 1 = network side, 0 = terminal side |
| filter_mode | input | 1 | 1 = event only when the received nibble changes |
| baud_stb | input | 1 | One-cycle strobe per baud |
| frame_stb | input | 1 | Qualifies a baud strobe as the first baud of a frame |
| mf_sync | input | 1 | Qualifies a frame start as frame 1 |
| tx_nib | input | 4 | Host nibble for outgoing subchannels |
| tx_bytes | input | 16 | Host bytes for outgoing subchannels |
| rx_nib | input | 4 | Received Q / SC1 nibble |
| baud_pos | output | 6 | Current baud position, 0 = none |
| frame_pos | output | 5 | Current frame position, 0 = none |
| mf_event | output | 1 | One-cycle multiframe event |
| tx_hold | output | 20 | Stored outgoing subchannel bits |
| rx_hold | output | 4 | Stored received nibble |

## Verification
The hardest situation to reach is the boundary baud when the filter is on, with the received nibble either equal to or different from the one stored at the previous boundary. This happens once every 960 bauds, and only if the multiframe alignment has survived. The bench runs whole multiframes with naturally placed frame starts. It picks the role, filter and enable settings at random for each run, and it either keeps the received nibble or draws a new one. Directed phases add resynchronisation in the middle of a multiframe, a shortened frame and a disable period, so that the boundary moves to places the bench predicts.

// File: rtl/mfs_pkg.sv
// Shared types for the multiframe sequencer.
// Assumes: role is a single bit at the top-level port and cast here.
package mfs_pkg;
    typedef enum logic {
        ROLE_TE = 1'b0,
        ROLE_NT = 1'b1
    } role_e;

    // Returns 1 when a received nibble differs from the stored one.
    function automatic logic nib_changed(input logic [3:0] now_v, input logic [3:0] held_v);
        return now_v != held_v;
    endfunction
endpackage

// File: rtl/mfs_baud_ctr.sv
// Baud position counter inside one frame (1..BAUDS, 0 = not started).
// Assumes: baud_stb is a one-cycle strobe and frame_stb is only
// meaningful in the same cycle as baud_stb.
module mfs_baud_ctr #(
    parameter int BAUDS  = 48,
    localparam int BAUD_W = $clog2(BAUDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              baud_stb,
    input  logic              frame_stb,
    output logic [BAUD_W-1:0] pos,
    output logic              frame_go
);
    localparam logic [BAUD_W-1:0] LAST = BAUD_W'(BAUDS);
    localparam logic [BAUD_W-1:0] ONE  = BAUD_W'(1);

    // A frame begins on an explicit start or on wrap from the last / idle slot.
    assign frame_go = run && baud_stb && (frame_stb || pos == LAST || pos == '0);

    // Advance the baud position on each strobe, hold at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos <= '0;
        end else if (baud_stb) begin
            if (frame_go) pos <= ONE;
            else          pos <= pos + ONE;
        end
    end

    AST_BAUD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);                                                   // R2
    AST_BAUD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (run && baud_stb && frame_stb) |=> (pos == ONE));               // R2
endmodule

// File: rtl/mfs_frame_ctr.sv
// Frame position counter inside one multiframe (1..FRAMES, 0 = not started).
// Assumes: frame_go is a one-cycle pulse from the baud counter and mf_sync
// is only meaningful with it.
module mfs_frame_ctr #(
    parameter int FRAMES  = 20,
    localparam int FRAME_W = $clog2(FRAMES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               frame_go,
    input  logic               mf_sync,
    output logic [FRAME_W-1:0] pos
);
    localparam logic [FRAME_W-1:0] LAST = FRAME_W'(FRAMES);
    localparam logic [FRAME_W-1:0] ONE  = FRAME_W'(1);

    // Step the frame position at each frame start; resync or wrap to one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos <= '0;
        end else if (frame_go) begin
            if (mf_sync || pos == LAST) pos <= ONE;
            else                        pos <= pos + ONE;
        end
    end

    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);                                                   // R3
    AST_FRAME_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frame_go && mf_sync) |=> (pos == ONE));                 // R3
    AST_FRAME_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_go) |=> $stable(pos));                           // R3
endmodule

// File: rtl/mfs_capture.sv
// Boundary capture: stores outgoing subchannel bits (network side only),
// the received nibble (both roles), and produces the event pulse.
// Assumes: cap_tick is a one-cycle pulse once per multiframe.
module mfs_capture
    import mfs_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 2,
    localparam int TX_W   = NIB_W + N_BYTES * BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_tick,
    input  logic                      evt_enable,
    input  logic                      filter_mode,
    input  role_e                     role,
    input  logic [NIB_W-1:0]          tx_nib,
    input  logic [N_BYTES*BYTE_W-1:0] tx_bytes,
    input  logic [NIB_W-1:0]          rx_nib,
    output logic [TX_W-1:0]           tx_hold,
    output logic [NIB_W-1:0]          rx_hold,
    output logic                      mf_event
);
    logic tx_load;
    logic fresh;

    assign tx_load = cap_tick && (role == ROLE_NT);
    assign fresh   = nib_changed(rx_nib, rx_hold);

    // Nibble slice of the outgoing hold register.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_hold[TX_W-1 -: NIB_W] <= '0;
        else if (tx_load) tx_hold[TX_W-1 -: NIB_W] <= tx_nib;
    end

    // One byte slice of the outgoing hold register per generated lane.
    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)       tx_hold[g*BYTE_W +: BYTE_W] <= '0;
            else if (tx_load) tx_hold[g*BYTE_W +: BYTE_W] <= tx_bytes[g*BYTE_W +: BYTE_W];
        end
    end

    // Received nibble is stored at every boundary regardless of role.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_hold <= '0;
        else if (cap_tick) rx_hold <= rx_nib;
    end

    // Event pulse: boundary, enabled, and (filter off or content new).
    always_ff @(posedge clk) begin
        if (!rst_n) mf_event <= 1'b0;
        else        mf_event <= cap_tick && evt_enable && (!filter_mode || fresh);
    end

    AST_TX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_load |=> $stable(tx_hold));                                 // R4
    AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_tick |=> $stable(rx_hold));                                // R9
    AST_RX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_tick |=> (rx_hold == $past(rx_nib)));                       // R5
    AST_FILTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_tick && filter_mode && (rx_nib == rx_hold)) |=> !mf_event); // R7
    AST_EVT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_enable |=> !mf_event);                                     // R8
endmodule

// File: rtl/mframe_seq.sv
// Multiframe sequencer top: baud and frame counters plus boundary capture.
// Assumes: one baud strobe is never followed by another in the next cycle
// only if the line is slower than the clock; back-to-back strobes are legal.
module mframe_seq #(
    parameter int BAUDS    = 48,
    parameter int FRAMES   = 20,
    parameter int EVT_BAUD = 47,
    parameter int NIB_W    = 4,
    parameter int BYTE_W   = 8,
    parameter int N_BYTES  = 2,
    localparam int BAUD_W  = $clog2(BAUDS + 1),
    localparam int FRAME_W = $clog2(FRAMES + 1),
    localparam int TX_W    = NIB_W + N_BYTES * BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mf_enable,
    input  logic                      evt_enable,
    input  logic                      role_nt,
    input  logic                      filter_mode,
    input  logic                      baud_stb,
    input  logic                      frame_stb,
    input  logic                      mf_sync,
    input  logic [NIB_W-1:0]          tx_nib,
    input  logic [N_BYTES*BYTE_W-1:0] tx_bytes,
    input  logic [NIB_W-1:0]          rx_nib,
    output logic [BAUD_W-1:0]         baud_pos,
    output logic [FRAME_W-1:0]        frame_pos,
    output logic                      mf_event,
    output logic [TX_W-1:0]           tx_hold,
    output logic [NIB_W-1:0]          rx_hold
);
    import mfs_pkg::*;

    localparam logic [BAUD_W-1:0]  PRE_EVT  = BAUD_W'(EVT_BAUD - 1);
    localparam logic [BAUD_W-1:0]  EVT_POS  = BAUD_W'(EVT_BAUD);
    localparam logic [FRAME_W-1:0] LAST_FRM = FRAME_W'(FRAMES);

    logic  frame_go;
    logic  cap_tick;
    role_e role;

    assign role = role_e'(role_nt);

    // Boundary: the strobe that moves the baud position onto EVT_BAUD in the last frame.
    assign cap_tick = mf_enable && baud_stb && !frame_stb
                   && baud_pos == PRE_EVT && frame_pos == LAST_FRM;

    mfs_baud_ctr #(.BAUDS(BAUDS)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mf_enable),
        .baud_stb (baud_stb),
        .frame_stb(frame_stb),
        .pos      (baud_pos),
        .frame_go (frame_go)
    );

    mfs_frame_ctr #(.FRAMES(FRAMES)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (mf_enable),
        .frame_go(frame_go),
        .mf_sync (mf_sync),
        .pos     (frame_pos)
    );

    mfs_capture #(.NIB_W(NIB_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_tick   (cap_tick),
        .evt_enable (evt_enable),
        .filter_mode(filter_mode),
        .role       (role),
        .tx_nib     (tx_nib),
        .tx_bytes   (tx_bytes),
        .rx_nib     (rx_nib),
        .tx_hold    (tx_hold),
        .rx_hold    (rx_hold),
        .mf_event   (mf_event)
    );

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_enable |=> (baud_pos == '0 && frame_pos == '0));             // R1
    AST_EVT_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        mf_event |-> (baud_pos == EVT_POS && frame_pos == LAST_FRM));   // R6
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mf_event |=> !mf_event);                                        // R6
endmodule

// File: tb/mframe_seq_test.sv
module mframe_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mf_enable = 1'b0, evt_enable = 1'b0, role_nt = 1'b0, filter_mode = 1'b0;
    logic        baud_stb = 1'b0, frame_stb = 1'b0, mf_sync = 1'b0;
    logic [3:0]  tx_nib = '0;
    logic [15:0] tx_bytes = '0;
    logic [3:0]  rx_nib = '0;
    logic [5:0]  baud_pos;
    logic [4:0]  frame_pos;
    logic        mf_event;
    logic [19:0] tx_hold;
    logic [3:0]  rx_hold;

    int n_cmp = 0, n_bad = 0, n_evt = 0;
    bit done = 1'b0;
    // Reference model state
    int m_baud = 0, m_frame = 0, m_tx = 0, m_rx = 0, m_ev = 0;

    mframe_seq uut (
        .clk(clk), .rst_n(rst_n), .mf_enable(mf_enable), .evt_enable(evt_enable),
        .role_nt(role_nt), .filter_mode(filter_mode), .baud_stb(baud_stb),
        .frame_stb(frame_stb), .mf_sync(mf_sync), .tx_nib(tx_nib), .tx_bytes(tx_bytes),
        .rx_nib(rx_nib), .baud_pos(baud_pos), .frame_pos(frame_pos), .mf_event(mf_event),
        .tx_hold(tx_hold), .rx_hold(rx_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int nat_fs();
        return (m_baud == 48 || m_baud == 0) ? 1 : 0;
    endfunction

    function automatic int nat_ms();
        return (nat_fs() == 1 && (m_frame == 20 || m_frame == 0)) ? 1 : 0;
    endfunction

    // Apply one baud strobe, update the model from the requirements, compare.
    task automatic step(input bit fs, input bit ms);
        int tick;
        @(negedge clk);
        tx_nib    = 4'($urandom);
        tx_bytes  = 16'($urandom);
        baud_stb  = 1'b1;
        frame_stb = fs;
        mf_sync   = ms;
        tick = (mf_enable && !fs && m_baud == 46 && m_frame == 20) ? 1 : 0;
        if (!mf_enable) begin
            m_baud = 0; m_frame = 0; m_ev = 0;
        end else begin
            if (fs || m_baud == 48 || m_baud == 0) begin
                m_baud  = 1;
                m_frame = (ms || m_frame == 20) ? 1 : m_frame + 1;
            end else begin
                m_baud = m_baud + 1;
            end
            m_ev = (tick == 1 && evt_enable && (!filter_mode || int'(rx_nib) != m_rx)) ? 1 : 0;
            if (tick == 1) begin
                m_rx = int'(rx_nib);
                if (role_nt) m_tx = int'({tx_nib, tx_bytes});
            end
        end
        @(negedge clk);
        baud_stb = 1'b0; frame_stb = 1'b0; mf_sync = 1'b0;
        chk("R2", "baud_pos", int'(baud_pos), m_baud);
        chk("R3", "frame_pos", int'(frame_pos), m_frame);
        chk("R6", "mf_event", int'(mf_event), m_ev);
        chk("R4", "tx_hold", int'(tx_hold), m_tx);
        chk("R5", "rx_hold", int'(rx_hold), m_rx);
        if (mf_event) n_evt++;
        @(negedge clk);
        chk("R6", "mf_event idle", int'(mf_event), 0);
        chk("R9", "rx_hold idle", int'(rx_hold), m_rx);
    endtask

    task automatic run_bauds(input int n);
        for (int i = 0; i < n; i++) step(bit'(nat_fs()), bit'(nat_ms()));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        int ev0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 / R1: reset state
        chk("R9", "reset baud_pos", int'(baud_pos), 0);
        chk("R9", "reset frame_pos", int'(frame_pos), 0);
        chk("R9", "reset tx_hold", int'(tx_hold), 0);
        chk("R9", "reset rx_hold", int'(rx_hold), 0);
        chk("R9", "reset mf_event", int'(mf_event), 0);

        // R1: strobes while disabled leave the counters at zero
        evt_enable = 1'b1; role_nt = 1'b1;
        for (int i = 0; i < 60; i++) step(bit'(i % 48 == 0), 1'b0);
        chk("R1", "disabled baud_pos", int'(baud_pos), 0);

        // R6 / R4 / R5: network side, filter off, two multiframes
        mf_enable = 1'b1; rx_nib = 4'h5;
        ev0 = n_evt;
        run_bauds(1920);
        chk("R6", "events in two multiframes", n_evt - ev0, 2);

        // R4: terminal side keeps tx_hold
        role_nt = 1'b0; rx_nib = 4'h9;
        run_bauds(960);

        // R7: filter with constant nibble -> no event; changed nibble -> event
        filter_mode = 1'b1; role_nt = 1'b1;
        ev0 = n_evt;
        run_bauds(960);
        chk("R7", "filter same nibble events", n_evt - ev0, 0);
        rx_nib = 4'h3;
        ev0 = n_evt;
        run_bauds(960);
        chk("R7", "filter new nibble events", n_evt - ev0, 1);

        // R8: events disabled, capture continues
        filter_mode = 1'b0; evt_enable = 1'b0; rx_nib = 4'hC;
        ev0 = n_evt;
        run_bauds(960);
        chk("R8", "events while disabled", n_evt - ev0, 0);
        chk("R8", "rx_hold captured", int'(rx_hold), 12);

        // R3 / R2: resync mid-multiframe and a shortened frame
        evt_enable = 1'b1;
        run_bauds(300);
        step(1'b1, 1'b1);
        run_bauds(20);
        step(1'b1, 1'b0);
        run_bauds(1000);

        // R1: drop enable mid-multiframe
        mf_enable = 1'b0;
        run_bauds(30);
        mf_enable = 1'b1;
        run_bauds(500);

        // Random multiframes with random modes
        for (int r = 0; r < 20; r++) begin
            role_nt     = 1'($urandom);
            filter_mode = 1'($urandom);
            evt_enable  = ($urandom % 4) != 0;
            if ($urandom % 2 == 1) rx_nib = 4'($urandom);
            if ($urandom % 5 == 0) begin
                mf_enable = 1'b0;
                run_bauds(int'($urandom % 40) + 1);
                mf_enable = 1'b1;
            end
            for (int i = 0; i < 960; i++) begin
                bit fs, ms;
                fs = bit'(nat_fs());
                ms = bit'(nat_ms());
                if ($urandom % 700 == 0) fs = 1'b1;
                if (fs && $urandom % 60 == 0) ms = 1'b1;
                step(fs, ms);
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule